// File: doc/BRIEF.md
# Display Buffer Address Generator

This block turns display-side requests into word addresses inside a graphics memory aperture. The memory is viewed as 32-bit words. Each result is a 20-bit word offset into an aperture of up to 4 MB, four byte lanes, and the matching system byte address. The aperture base is programmable in 512 KB steps.

There are three kinds of request. A pixel request returns the word that holds one pixel, with lanes for that pixel only. A compressed-data request returns one word of a line's compressed record. A scan request walks the visible frame from a chosen start line to the bottom. It issues one word per accepted output beat and flags the final word.

The frame buffer is laid out in XY form. The line number sits above the byte position within the line, and the gap between the two depends on the mode. In the narrower modes a line leaves spare room at its end, and the line's compressed record goes there. In the 1024-pixel-wide modes the visible line fills the whole pitch, so the compressed records live in a separate linear region.

Requests enter on a valid/ready port and results leave on a valid/ready port. A request is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. A result is consumed when `out_valid` and `out_ready` are both high at an edge. While `out_valid` is high and `out_ready` is low, the result stays unchanged. `cmd_ready` stays low while a scan still has words to issue, and also while the output holds an unconsumed result that is not being taken in the same cycle. Mode and base inputs are plain levels.

Top module: `disp_addr_gen`

## Requirements
- R1: The mode pair 1280-wide at 16 bpp (`res_sel`=3, `bpp16`=1) raises `mode_err` in the same cycle. While it is high, requests are accepted and dropped, any held result is flushed at the next edge, and a running scan is abandoned without resuming.
- R2: A pixel request (`cmd_kind`=0, or the unused code 3) gives `out_off` = {line, byte position} / 4. The byte position is X at 8 bpp and 2·X at 16 bpp. The line pitch is 1024 bytes for 8-bpp modes other than 1280-wide, and 2048 bytes for every 16-bpp mode and for 1280-wide at 8 bpp. `res_sel` codes are 0=640x480, 1=800x600, 2=1024x768, 3=1280x1024.
- R3: A pixel result enables only its own lanes. At 8 bpp it is bit (X mod 4) alone, with the lowest X in byte 0. At 16 bpp it is 4'b0011 for even X and 4'b1100 for odd X. Compressed and scan results enable all four lanes.
- R4: A compressed request (`cmd_kind`=1) in the 640- and 800-wide modes, and in 1280-wide at 8 bpp, returns line start + visible words per line + index. The index is `cmd_x`.
- R5: A compressed request in the 1024-wide modes returns (`cmp_base` + Y·`cmp_line_dw` + index) mod 2^20.
- R6: A scan request (`cmd_kind`=2) issues line start + w for w = 0 up to the last visible word, then moves to the next line. `out_eof` is high only on the word of the last visible line that has the highest offset.
- R7: The scan begins at line `cmd_y`. `cmd_ready` is low while words remain after the one in the output, and low while an unconsumed result is held and `out_ready` is low.
- R8: An accepted request yields a result one cycle later. A result held under back-pressure keeps `out_off`, `out_be` and `out_eof` stable.
- R9: `out_sysaddr` = `apt_base`·512 KB + 4·`out_off`, taken modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_sel | input | 2 | Resolution code: 0=640x480, 1=800x600, 2=1024x768, 3=1280x1024 |
| bpp16 | input | 1 | 1 = 16 bpp, 0 = 8 bpp |
| cmp_base | input | 20 | Word offset where the linear compressed region starts |
| cmp_line_dw | input | 10 | Compressed words per line in the linear region |
| apt_base | input | 13 | Aperture start, in 512 KB units |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request accepted at this edge if valid |
| cmd_kind | input | 2 | 0 pixel, 1 compressed word, 2 scan, 3 treated as pixel |
| cmd_x | input | 11 | Pixel X, or compressed word index |
| cmd_y | input | 10 | Line number, or scan start line |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_off | output | 20 | Word offset inside the aperture |
| out_be | output | 4 | Byte lane enables |
| out_eof | output | 1 | Final word of a scan |
| out_sysaddr | output | 32 | System byte address of the word |
| mode_err | output | 1 | Illegal mode selected |

## Verification
Two things can coincide on one edge. The consumer can take a scan's final word at the same edge the block accepts a new pixel request. An illegal mode can also arrive while a scan is partway through its lines. The first case is provoked by queuing a pixel request behind a scan while `out_ready` is random. The reference model predicts `cmd_ready` every cycle from its count of words still owed, so acceptance must fall exactly on the cycle the flagged word leaves. The second case holds the output stalled, switches to the illegal mode mid-scan and later switches back. The bench then judges that the held word vanished after one edge and that no further scan words ever appear.

// File: rtl/dbag_pkg.sv
package dbag_pkg;
  localparam int DW_W = 10;
  localparam int PLD_NARROW = 8;
  localparam int PLD_WIDE = 9;

  typedef enum logic [1:0] {
    RES_640  = 2'd0,
    RES_800  = 2'd1,
    RES_1024 = 2'd2,
    RES_1280 = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    K_PIX  = 2'd0,
    K_CMP  = 2'd1,
    K_SCAN = 2'd2,
    K_RSV  = 2'd3
  } kind_e;

  typedef struct packed {
    logic [DW_W-1:0] width_dw;
    logic [DW_W-1:0] last_line;
    logic            pitch_wide;
    logic            gap;
    logic            err;
  } geom_t;
endpackage

// File: rtl/dbag_mode_dec.sv
module dbag_mode_dec
  import dbag_pkg::*;
(
  input  logic [1:0] res_sel,
  input  logic       bpp16,
  output geom_t      geom
);
  res_e        res;
  logic [10:0] px_w;
  logic [10:0] lines;

  always_comb begin
    res = res_e'(res_sel);
    unique case (res)
      RES_640:  begin px_w = 11'd640;  lines = 11'd480;  end
      RES_800:  begin px_w = 11'd800;  lines = 11'd600;  end
      RES_1024: begin px_w = 11'd1024; lines = 11'd768;  end
      default:  begin px_w = 11'd1280; lines = 11'd1024; end
    endcase
    geom.width_dw   = bpp16 ? px_w[10:1] : {1'b0, px_w[10:2]};
    geom.last_line  = DW_W'(lines - 11'd1);
    geom.pitch_wide = bpp16 || (res == RES_1280);
    geom.gap        = (res != RES_1024);
    geom.err        = bpp16 && (res == RES_1280);
  end
endmodule

// File: rtl/dbag_addr_calc.sv
module dbag_addr_calc
  import dbag_pkg::*;
#(
  parameter int OFF_W = 20,
  parameter int X_W   = 11,
  parameter int Y_W   = 10,
  parameter int CL_W  = 10
) (
  input  logic [1:0]      kind,
  input  logic [X_W-1:0]  x,
  input  logic [Y_W-1:0]  y,
  input  logic [DW_W-1:0] width_dw,
  input  logic            pitch_wide,
  input  logic            gap,
  input  logic            bpp16,
  input  logic [OFF_W-1:0] cmp_base,
  input  logic [CL_W-1:0] cmp_line,
  output logic [OFF_W-1:0] off,
  output logic [3:0]      be
);
  localparam int PW = Y_W + CL_W;

  logic [OFF_W-1:0] line_base;
  logic [X_W-1:0]   word_x;
  logic [OFF_W-1:0] fb_off;
  logic [OFF_W-1:0] gap_off;
  logic [OFF_W-1:0] lin_off;
  logic [PW-1:0]    prod;

  always_comb begin
    line_base = OFF_W'(y) << (pitch_wide ? PLD_WIDE : PLD_NARROW);
    word_x    = bpp16 ? {1'b0, x[X_W-1:1]} : {2'b00, x[X_W-1:2]};
    fb_off    = line_base | OFF_W'(word_x);
    gap_off   = line_base + OFF_W'(width_dw) + OFF_W'(x);
    prod      = PW'(y) * PW'(cmp_line);
    lin_off   = cmp_base + OFF_W'(prod) + OFF_W'(x);
    if (kind_e'(kind) == K_CMP) begin
      off = gap ? gap_off : lin_off;
      be  = 4'hF;
    end else begin
      off = fb_off;
      if (bpp16) be = x[0] ? 4'b1100 : 4'b0011;
      else       be = 4'b0001 << x[1:0];
    end
  end
endmodule

// File: rtl/dbag_scan_seq.sv
module dbag_scan_seq
  import dbag_pkg::*;
#(
  parameter int OFF_W = 20,
  parameter int Y_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             abort,
  input  logic [Y_W-1:0]   start_y,
  input  logic [DW_W-1:0]  width_dw,
  input  logic [DW_W-1:0]  last_line,
  input  logic             pitch_wide,
  output logic             busy,
  output logic [OFF_W-1:0] first_off,
  output logic [OFF_W-1:0] cur_off,
  output logic             cur_last
);
  logic [Y_W-1:0]  line_q;
  logic [DW_W-1:0] word_q;
  logic            row_end;

  always_comb begin
    row_end   = (word_q == width_dw - DW_W'(1));
    cur_last  = row_end && (DW_W'(line_q) == last_line);
    cur_off   = (OFF_W'(line_q) << (pitch_wide ? PLD_WIDE : PLD_NARROW)) | OFF_W'(word_q);
    first_off = OFF_W'(start_y) << (pitch_wide ? PLD_WIDE : PLD_NARROW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      line_q <= '0;
      word_q <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      line_q <= start_y;
      word_q <= DW_W'(1);
    end else if (step) begin
      if (row_end) begin
        word_q <= '0;
        if (cur_last) busy <= 1'b0;
        else          line_q <= line_q + Y_W'(1);
      end else begin
        word_q <= word_q + DW_W'(1);
      end
    end
  end
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
  import dbag_pkg::*;
#(
  parameter int OFF_W      = 20,
  parameter int X_W        = 11,
  parameter int Y_W        = 10,
  parameter int CL_W       = 10,
  parameter int APT_W      = 13,
  parameter int APT_SHIFT  = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           res_sel,
  input  logic                 bpp16,
  input  logic [OFF_W-1:0]     cmp_base,
  input  logic [CL_W-1:0]      cmp_line_dw,
  input  logic [APT_W-1:0]     apt_base,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [1:0]           cmd_kind,
  input  logic [X_W-1:0]       cmd_x,
  input  logic [Y_W-1:0]       cmd_y,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OFF_W-1:0]     out_off,
  output logic [3:0]           out_be,
  output logic                 out_eof,
  output logic [APT_W+APT_SHIFT-1:0] out_sysaddr,
  output logic                 mode_err
);
  localparam int SYS_W = APT_W + APT_SHIFT;

  geom_t            geom;
  logic [OFF_W-1:0] calc_off;
  logic [3:0]       calc_be;
  logic             busy;
  logic [OFF_W-1:0] scan_first;
  logic [OFF_W-1:0] scan_off;
  logic             scan_last;
  logic             slot_free;
  logic             accept;
  logic             is_scan;

  dbag_mode_dec u_dec (
    .res_sel (res_sel),
    .bpp16   (bpp16),
    .geom    (geom)
  );

  dbag_addr_calc #(.OFF_W(OFF_W), .X_W(X_W), .Y_W(Y_W), .CL_W(CL_W)) u_calc (
    .kind       (cmd_kind),
    .x          (cmd_x),
    .y          (cmd_y),
    .width_dw   (geom.width_dw),
    .pitch_wide (geom.pitch_wide),
    .gap        (geom.gap),
    .bpp16      (bpp16),
    .cmp_base   (cmp_base),
    .cmp_line   (cmp_line_dw),
    .off        (calc_off),
    .be         (calc_be)
  );

  always_comb begin
    slot_free = !out_valid || out_ready;
    cmd_ready = !busy && (geom.err || slot_free);
    accept    = cmd_valid && cmd_ready;
    is_scan   = (kind_e'(cmd_kind) == K_SCAN);
    mode_err  = geom.err;
  end

  dbag_scan_seq #(.OFF_W(OFF_W), .Y_W(Y_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept && is_scan && !geom.err),
    .step       (busy && slot_free),
    .abort      (geom.err),
    .start_y    (cmd_y),
    .width_dw   (geom.width_dw),
    .last_line  (geom.last_line),
    .pitch_wide (geom.pitch_wide),
    .busy       (busy),
    .first_off  (scan_first),
    .cur_off    (scan_off),
    .cur_last   (scan_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_off   <= '0;
      out_be    <= '0;
      out_eof   <= 1'b0;
    end else if (geom.err) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_eof   <= 1'b0;
      if (is_scan) begin
        out_off <= scan_first;
        out_be  <= 4'hF;
      end else begin
        out_off <= calc_off;
        out_be  <= calc_be;
      end
    end else if (busy && slot_free) begin
      out_valid <= 1'b1;
      out_off   <= scan_off;
      out_be    <= 4'hF;
      out_eof   <= scan_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_sysaddr = SYS_W'({apt_base, {APT_SHIFT{1'b0}}}) + SYS_W'({out_off, 2'b00});
endmodule

// File: rtl/dbag_chk.sv
module dbag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        mode_err,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_eof,
  input logic [3:0]  out_be,
  input logic [19:0] out_off
);
  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !mode_err |=> out_valid && $stable(out_off) && $stable(out_be) && $stable(out_eof));

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !mode_err |=> out_valid);

  // R1
  err_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> !out_valid);

  // R6
  eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> !(out_valid && out_eof));

  // R3
  lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_be) == 1) || (out_be == 4'b0011) || (out_be == 4'b1100) || (out_be == 4'hF));
endmodule

bind disp_addr_gen dbag_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .mode_err  (mode_err),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_eof   (out_eof),
  .out_be    (out_be),
  .out_off   (out_off)
);

// File: tb/disp_addr_gen_bench.sv
module disp_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic        bpp16 = 1'b0;
  logic [19:0] cmp_base = '0;
  logic [9:0]  cmp_line_dw = '0;
  logic [12:0] apt_base = 13'h1A3;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_kind = '0;
  logic [10:0] cmd_x = '0;
  logic [9:0]  cmd_y = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_off;
  logic [3:0]  out_be;
  logic        out_eof;
  logic [31:0] out_sysaddr;
  logic        mode_err;

  always #5 clk = ~clk;

  disp_addr_gen u_disp_addr_gen (
    .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .bpp16(bpp16),
    .cmp_base(cmp_base), .cmp_line_dw(cmp_line_dw), .apt_base(apt_base),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_off(out_off), .out_be(out_be), .out_eof(out_eof),
    .out_sysaddr(out_sysaddr), .mode_err(mode_err)
  );

  typedef struct {
    int    off;
    int    be;
    int    eof;
    string tag;
  } beat_t;

  beat_t q[$];
  int    checks = 0;
  int    fails = 0;
  int    bp = 0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int px_w(); return res_sel == 0 ? 640 : res_sel == 1 ? 800 : res_sel == 2 ? 1024 : 1280; endfunction
  function automatic int n_lines(); return res_sel == 0 ? 480 : res_sel == 1 ? 600 : res_sel == 2 ? 768 : 1024; endfunction
  function automatic int bpb(); return bpp16 ? 2 : 1; endfunction
  function automatic int pitch(); return (bpp16 || res_sel == 3) ? 2048 : 1024; endfunction
  function automatic bit illegal(); return bpp16 && res_sel == 3; endfunction

  always @(negedge clk) begin
    if (bp == 0) out_ready <= 1'b1;
    else if (bp == 1) out_ready <= ($urandom % 3) != 0;
    else out_ready <= 1'b0;
  end

  // Reference model, compared every clock
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(out_valid == (q.size() > 0), "R8 out_valid", out_valid, q.size() > 0);
      chk(cmd_ready == ((q.size() <= 1) && (illegal() || q.size() == 0 || out_ready)),
          "R7 cmd_ready", cmd_ready, (q.size() <= 1) && (illegal() || q.size() == 0 || out_ready));
      chk(mode_err == illegal(), "R1 mode_err", mode_err, illegal());
      if (out_valid && out_ready && q.size() > 0) begin
        beat_t b;
        logic [31:0] sa;
        b = q.pop_front();
        sa = 32'(apt_base) * 32'd524288 + 32'(b.off) * 32'd4;
        chk(out_off == 20'(b.off), b.tag, out_off, b.off);
        chk(out_be == 4'(b.be), "R3 out_be", out_be, b.be);
        chk(out_eof == b.eof[0], "R6 out_eof", out_eof, b.eof);
        chk(out_sysaddr == sa, "R9 out_sysaddr", out_sysaddr, sa);
      end
      if (illegal()) q.delete();
    end
  end

  task automatic send(input int kind, input int x, input int y);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_kind = 2'(kind);
    cmd_x = 11'(x);
    cmd_y = 10'(y);
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    if (!illegal()) begin
      if (kind == 2) begin
        int wd;
        wd = px_w() * bpb() / 4;
        for (int yy = y; yy < n_lines(); yy++)
          for (int d = 0; d < wd; d++)
            q.push_back('{(yy * pitch()) / 4 + d, 15, (yy == n_lines() - 1 && d == wd - 1) ? 1 : 0, "R6 scan off"});
      end else if (kind == 1) begin
        if (res_sel == 2)
          q.push_back('{int'((longint'(cmp_base) + longint'(y) * cmp_line_dw + x) % 1048576), 15, 0, "R5 linear off"});
        else
          q.push_back('{(y * pitch() + px_w() * bpb()) / 4 + x, 15, 0, "R4 gap off"});
      end else begin
        q.push_back('{(y * pitch() + x * bpb()) / 4,
                      bpp16 ? ((x % 2) ? 12 : 3) : (1 << (x % 4)), 0, "R2 pixel off"});
      end
    end
    #1 cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mode(input int r, input bit b);
    @(negedge clk);
    res_sel = 2'(r);
    bpp16 = b;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R6 actual=hang expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    chk(cmd_ready == 1'b1, "R7 reset cmd_ready", cmd_ready, 1);
    chk(mode_err == 1'b0, "R1 reset mode_err", mode_err, 0);

    // R2 R3: 640x480 8bpp pixels, all lane positions
    set_mode(0, 0);
    for (int i = 0; i < 8; i++) send(0, i, 0);
    send(0, 639, 479);
    send(3, 5, 7);
    bp = 1;
    send(0, 123, 45);
    drain();

    // R2 R3: 16 bpp and wide 8 bpp pixels
    set_mode(1, 1);
    send(0, 799, 599);
    send(0, 1, 3);
    send(0, 2, 3);
    set_mode(3, 0);
    send(0, 1279, 1023);
    set_mode(2, 1);
    send(0, 1023, 767);
    set_mode(2, 0);
    send(0, 1023, 767);
    drain();

    // R4 R5: compressed words in gap and linear layouts
    bp = 0;
    set_mode(1, 0);
    send(1, 3, 5);
    set_mode(3, 0);
    send(1, 0, 10);
    set_mode(0, 1);
    send(1, 7, 479);
    @(negedge clk);
    cmp_base = 20'h30000;
    cmp_line_dw = 10'd40;
    set_mode(2, 0);
    send(1, 39, 767);
    @(negedge clk);
    cmp_base = 20'hFFFF0;
    cmp_line_dw = 10'd64;
    set_mode(2, 1);
    send(1, 5, 2);
    drain();

    // R6 R7 R9: scans from late start lines, back-pressure, pixel queued behind
    apt_base = 13'h1FFF;
    bp = 1;
    set_mode(0, 0);
    send(2, 0, 478);
    send(0, 9, 9);
    drain();
    set_mode(2, 1);
    send(2, 0, 766);
    send(1, 1, 1);
    drain();
    bp = 0;
    set_mode(3, 0);
    send(2, 0, 1022);
    drain();
    set_mode(1, 1);
    send(2, 0, 599);
    drain();

    // R1: illegal mode while idle drops requests
    set_mode(3, 1);
    send(0, 4, 4);
    repeat (4) begin
      @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R1 dropped request", out_valid, 0);
    end
    set_mode(0, 0);
    drain();

    // R1: illegal mode mid-scan flushes and abandons
    send(2, 0, 470);
    repeat (20) @(negedge clk);
    bp = 2;
    @(negedge clk);
    set_mode(3, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 flushed scan", out_valid, 0);
    set_mode(0, 0);
    bp = 0;
    repeat (10) begin
      @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R1 scan not resumed", out_valid, 0);
    end
    send(0, 2, 2);
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule